// File: doc/BRIEF.md
# Front Panel Refresh Sequencer

This block is the controller-side engine that keeps a multiplexed front panel alive. It drives a small address/data/strobe bus toward the panel's registers. For each of the seven digit/annunciator/switch banks it runs a fixed seven-operation protocol. The first three operations blank the panel. The next three load the annunciator pattern, load the digit segments and select the bank. The last one reads back the switch buffer of the selected bank. The display content comes from an internal lookup interface: the block presents the bank index it is working on and receives that bank's annunciator and segment bytes in the same cycle.

Each captured switch word is reported with its bank index. When any bit of the word is zero, meaning a key wants attention, a one-clock key-change pulse is raised. The read at the end of every bank is also what keeps the panel's inactivity blanking circuit charged. The refresh therefore loops for as long as the `run` input stays high.

Top module: `panel_refresh_seq`

## Requirements
- R1: While `rst` is high, and afterwards until `run` is seen high, `bus_wr`, `bus_rd`, `sw_valid` and `key_chg` are all low.
- R2: When `run` is sampled high by a clock edge while idle, the strobe of the first operation is high from that edge onward. The first operation is a write to the annunciator register.
- R3: Register addresses are: annunciator = 0, digit segments = 1, select = 2, switch buffer = 3. Each bank opens with three writes in this order: address 0 with 0x00, address 1 with 0x00, address 2 with 0xFF.
- R4: The fourth operation writes address 0. Bits 6:0 are `tbl_ann[6:0]` for the current bank, and bit 7 is forced to 0 whatever `tbl_ann[7]` holds.
- R5: The fifth operation writes address 1 with `tbl_seg` of the current bank on all eight bits.
- R6: The sixth operation writes address 2 with a byte in which only bit b is 0, where b is the current bank (0..6). Bit 7 and all other bits are 1.
- R7: The seventh operation reads address 3. The value on `bus_rdata` during the last strobe clock is reported once on `sw_word` with `sw_bank` = b, and `sw_valid` is high for exactly one clock.
- R8: `key_chg` is high for exactly that one clock when the reported word contains at least one 0 bit. It is low in every other case.
- R9: Every operation holds its strobe high for exactly STB_CYCLES clocks, with address and write data unchanged. One low clock follows before the next operation.
- R10: Banks are served in order 0 to 6. After bank 6 the refresh restarts at bank 0 if `run` is high; otherwise the block goes idle. Dropping `run` never cuts a refresh short.
- R11: `bus_wr` and `bus_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables continuous refresh |
| tbl_bank | output | BANK_W | Bank index for the content lookup |
| tbl_ann | input | 8 | Annunciator pattern for `tbl_bank` |
| tbl_seg | input | 8 | Digit segment pattern for `tbl_bank` |
| bus_addr | output | 2 | Panel register address |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data from the switch buffer |
| sw_valid | output | 1 | Switch word valid pulse |
| sw_bank | output | BANK_W | Bank of the reported word |
| sw_word | output | 8 | Captured switch word |
| key_chg | output | 1 | One-clock pulse when the word has a zero bit |

## Verification
The bench feeds an annunciator table whose bit 7 is set for every bank. A design that passes that bit through would turn indirect addressing off on the panel, and the R4 data check would catch it. The panel model answers reads only for the bank picked by the last select write. A select byte with the wrong bit cleared would therefore return the wrong switch word or an all-ones word, so the key pulse would go missing or land on the wrong bank. `run` is dropped in the middle of a refresh and also pulsed for a single clock. A design that stops at once, or that keeps looping, would show too few or too many bus operations. Strobe length and stability are checked on every operation, so an off-by-one in the strobe timer shows up on the first write.

// File: rtl/panel_pkg.sv
package panel_pkg;

    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_ANN = 2'd0;
    localparam logic [1:0] ADDR_SEG = 2'd1;
    localparam logic [1:0] ADDR_SEL = 2'd2;
    localparam logic [1:0] ADDR_BUF = 2'd3;

    typedef enum logic [2:0] {
        ST_BLANK_ANN = 3'd0,
        ST_BLANK_SEG = 3'd1,
        ST_SEL_OFF   = 3'd2,
        ST_LOAD_ANN  = 3'd3,
        ST_LOAD_SEG  = 3'd4,
        ST_SEL_BANK  = 3'd5,
        ST_READ_SW   = 3'd6
    } step_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [1:0]        addr;
        logic [DATA_W-1:0] data;
    } bus_cmd_t;

    function automatic logic [DATA_W-1:0] sel_pattern(input logic [2:0] bank);
        logic [DATA_W-1:0] p;
        p = '1;
        p[bank] = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
    import panel_pkg::*;
#(
    parameter int N_BANKS    = 7,
    parameter int STB_CYCLES = 2,
    localparam int BANK_W    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
    localparam int PH_W      = $clog2(STB_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic              active,
    output step_t             step,
    output logic [BANK_W-1:0] bank,
    output logic              strobe_on,
    output logic              last_stb
);

    localparam logic [PH_W-1:0]   PH_GAP  = PH_W'(STB_CYCLES);
    localparam logic [PH_W-1:0]   PH_LAST = PH_W'(STB_CYCLES - 1);
    localparam logic [BANK_W-1:0] BANK_TOP = BANK_W'(N_BANKS - 1);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            step   <= ST_BLANK_ANN;
            bank   <= '0;
            ph     <= '0;
        end else if (!active) begin
            if (run) begin
                active <= 1'b1;
                step   <= ST_BLANK_ANN;
                bank   <= '0;
                ph     <= '0;
            end
        end else if (ph == PH_GAP) begin
            ph <= '0;
            if (step == ST_READ_SW) begin
                step <= ST_BLANK_ANN;
                if (bank == BANK_TOP) begin
                    bank   <= '0;
                    active <= run;
                end else begin
                    bank <= bank + 1'b1;
                end
            end else begin
                step <= step_t'(step + 3'd1);
            end
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assign strobe_on = active && (ph < PH_GAP);
    assign last_stb  = active && (ph == PH_LAST);

    AST_BANK_RANGE: assert property (@(posedge clk) disable iff (rst)
        bank <= BANK_TOP); // R10

endmodule

// File: rtl/panel_cmd_gen.sv
module panel_cmd_gen
    import panel_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  step_t             step,
    input  logic [BANK_W-1:0] bank,
    input  logic [DATA_W-1:0] ann,
    input  logic [DATA_W-1:0] seg,
    output bus_cmd_t          cmd
);

    always_comb begin
        cmd = '{wr: 1'b1, rd: 1'b0, addr: ADDR_ANN, data: '0};
        unique case (step)
            ST_BLANK_ANN: cmd.addr = ADDR_ANN;
            ST_BLANK_SEG: cmd.addr = ADDR_SEG;
            ST_SEL_OFF: begin
                cmd.addr = ADDR_SEL;
                cmd.data = '1;
            end
            ST_LOAD_ANN: begin
                cmd.addr = ADDR_ANN;
                cmd.data = {1'b0, ann[DATA_W-2:0]};
            end
            ST_LOAD_SEG: begin
                cmd.addr = ADDR_SEG;
                cmd.data = seg;
            end
            ST_SEL_BANK: begin
                cmd.addr = ADDR_SEL;
                cmd.data = sel_pattern(3'(bank));
            end
            ST_READ_SW: begin
                cmd.wr   = 1'b0;
                cmd.rd   = 1'b1;
                cmd.addr = ADDR_BUF;
            end
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/panel_sw_capture.sv
module panel_sw_capture
    import panel_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              rd_stb,
    input  logic [BANK_W-1:0] bank,
    input  logic [DATA_W-1:0] rdata,
    output logic              sw_valid,
    output logic [BANK_W-1:0] sw_bank,
    output logic [DATA_W-1:0] sw_word,
    output logic              key_chg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_valid <= 1'b0;
            sw_bank  <= '0;
            sw_word  <= '1;
            key_chg  <= 1'b0;
        end else begin
            sw_valid <= take;
            key_chg  <= take && !(&rdata);
            if (take) begin
                sw_word <= rdata;
                sw_bank <= bank;
            end
        end
    end

    AST_CAPT_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        sw_valid |-> $past(rd_stb)); // R7
    AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        sw_valid |=> !sw_valid); // R7
    AST_KEY_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        key_chg |-> sw_valid); // R8
    AST_KEY_HAS_ZERO: assert property (@(posedge clk) disable iff (rst)
        key_chg |-> ($countones(sw_word) < DATA_W)); // R8

endmodule

// File: rtl/panel_refresh_seq.sv
module panel_refresh_seq
    import panel_pkg::*;
#(
    parameter int N_BANKS    = 7,
    parameter int STB_CYCLES = 2,
    localparam int BANK_W    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [BANK_W-1:0] tbl_bank,
    input  logic [7:0]        tbl_ann,
    input  logic [7:0]        tbl_seg,
    output logic [1:0]        bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata,
    output logic              sw_valid,
    output logic [BANK_W-1:0] sw_bank,
    output logic [7:0]        sw_word,
    output logic              key_chg
);

    logic              active;
    step_t             step;
    logic [BANK_W-1:0] bank;
    logic              strobe_on;
    logic              last_stb;
    bus_cmd_t          cmd;

    panel_seq_ctrl #(
        .N_BANKS    (N_BANKS),
        .STB_CYCLES (STB_CYCLES)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .active    (active),
        .step      (step),
        .bank      (bank),
        .strobe_on (strobe_on),
        .last_stb  (last_stb)
    );

    panel_cmd_gen #(.BANK_W(BANK_W)) i_cmd (
        .step (step),
        .bank (bank),
        .ann  (tbl_ann),
        .seg  (tbl_seg),
        .cmd  (cmd)
    );

    assign tbl_bank  = bank;
    assign bus_addr  = cmd.addr;
    assign bus_wdata = cmd.data;
    assign bus_wr    = strobe_on & cmd.wr;
    assign bus_rd    = strobe_on & cmd.rd;

    panel_sw_capture #(.BANK_W(BANK_W)) i_cap (
        .clk      (clk),
        .rst      (rst),
        .take     (last_stb & cmd.rd),
        .rd_stb   (bus_rd),
        .bank     (bank),
        .rdata    (bus_rdata),
        .sw_valid (sw_valid),
        .sw_bank  (sw_bank),
        .sw_word  (sw_word),
        .key_chg  (key_chg)
    );

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd)); // R11
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && $past(bus_wr || bus_rd)) |-> ($stable(bus_addr) && $stable(bus_wdata))); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !active |-> !(bus_wr || bus_rd)); // R1
    AST_ANN_BIT7_LOW: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_ANN) |-> !bus_wdata[7]); // R4

endmodule

// File: tb/test_panel_refresh_seq.sv
module test_panel_refresh_seq;

    localparam int NB  = 7;
    localparam int STB = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [2:0] tbl_bank;
    logic [7:0] tbl_ann, tbl_seg;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       bus_wr, bus_rd, sw_valid, key_chg;
    logic [2:0] sw_bank;
    logic [7:0] sw_word;

    always #10 clk = ~clk;

    panel_refresh_seq #(.N_BANKS(NB), .STB_CYCLES(STB)) i_panel_refresh_seq (
        .clk(clk), .rst(rst), .run(run),
        .tbl_bank(tbl_bank), .tbl_ann(tbl_ann), .tbl_seg(tbl_seg),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sw_valid(sw_valid), .sw_bank(sw_bank), .sw_word(sw_word),
        .key_chg(key_chg)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ann_of(input int b);
        return {1'b1, 7'(b * 19 + 5)};
    endfunction
    function automatic logic [7:0] seg_of(input int b);
        return 8'(b * 37 + 129);
    endfunction

    assign tbl_ann = ann_of(int'(tbl_bank));
    assign tbl_seg = seg_of(int'(tbl_bank));

    // panel model
    logic [7:0] sw_model [NB];
    logic [7:0] sel_reg = 8'hFF;

    function automatic logic [7:0] rd_model(input logic [7:0] sel);
        logic [7:0] r;
        r = 8'hFF;
        for (int i = 0; i < NB; i++)
            if (sel == ~(8'd1 << i)) r = sw_model[i];
        return r;
    endfunction
    assign bus_rdata = rd_model(sel_reg);

    typedef struct {
        bit       rd;
        bit [1:0] addr;
        bit [7:0] data;
        int       bank;
    } op_t;
    typedef struct {
        int       bank;
        bit [7:0] word;
    } cap_t;

    op_t  exp_q[$];
    cap_t cap_q[$];
    int   ops_seen = 0;

    task automatic push_refresh();
        for (int b = 0; b < NB; b++) begin
            exp_q.push_back('{0, 2'd0, 8'h00, b});                   // R3
            exp_q.push_back('{0, 2'd1, 8'h00, b});                   // R3
            exp_q.push_back('{0, 2'd2, 8'hFF, b});                   // R3
            exp_q.push_back('{0, 2'd0, {1'b0, ann_of(b)[6:0]}, b});  // R4
            exp_q.push_back('{0, 2'd1, seg_of(b), b});               // R5
            exp_q.push_back('{0, 2'd2, ~(8'd1 << b), b});            // R6
            exp_q.push_back('{1, 2'd3, 8'h00, b});                   // R7
        end
    endtask

    // monitor
    bit       prev_stb = 0;
    int       stb_len  = 0;
    bit [1:0] cur_addr;
    bit [7:0] cur_data;

    always @(negedge clk) begin
        if (!rst) begin
            chk(!(bus_wr && bus_rd), "R11", {bus_wr, bus_rd}, 0);
            if ((bus_wr || bus_rd) && !prev_stb) begin
                ops_seen++;
                cur_addr = bus_addr;
                cur_data = bus_wdata;
                stb_len  = 1;
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected op", ops_seen, 0);
                end else begin
                    op_t e;
                    e = exp_q.pop_front();
                    chk(bus_rd == e.rd, "R10 op kind", bus_rd, e.rd);
                    chk(bus_addr == e.addr, "R3 addr", bus_addr, e.addr);
                    if (!e.rd) chk(bus_wdata == e.data, "R4/R5/R6 data", bus_wdata, e.data);
                    chk(tbl_bank == e.bank, "R10 bank", tbl_bank, e.bank);
                    if (e.rd) cap_q.push_back('{e.bank, sw_model[e.bank]});
                end
                if (bus_wr && bus_addr == 2'd2) sel_reg <= bus_wdata;
            end else if ((bus_wr || bus_rd) && prev_stb) begin
                stb_len++;
                chk(bus_addr == cur_addr && bus_wdata == cur_data, "R9 stable",
                    {bus_addr, bus_wdata}, {cur_addr, cur_data});
            end else if (prev_stb) begin
                chk(stb_len == STB, "R9 strobe len", stb_len, STB);
            end
            prev_stb = bus_wr || bus_rd;

            if (sw_valid) begin
                if (cap_q.size() == 0) begin
                    chk(0, "R7 unexpected capture", sw_word, 0);
                end else begin
                    cap_t c;
                    c = cap_q.pop_front();
                    chk(sw_word == c.word, "R7 word", sw_word, c.word);
                    chk(sw_bank == c.bank, "R7 bank", sw_bank, c.bank);
                    chk(key_chg == (c.word != 8'hFF), "R8 key", key_chg, c.word != 8'hFF);
                end
            end else if (key_chg) begin
                chk(0, "R8 stray key", key_chg, 0);
            end
        end
    end

    task automatic wait_drained(input int extra);
        int n = 0;
        while ((exp_q.size() != 0 || cap_q.size() != 0) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (extra) @(negedge clk);
    endtask

    task automatic main_seq();
        for (int i = 0; i < NB; i++) sw_model[i] = 8'hFF;
        sw_model[3] = 8'hF7;
        repeat (4) @(negedge clk);
        chk(!bus_wr && !bus_rd && !sw_valid && !key_chg, "R1 in reset",
            {bus_wr, bus_rd, sw_valid, key_chg}, 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(!bus_wr && !bus_rd && ops_seen == 0, "R1 idle without run", ops_seen, 0);

        push_refresh();
        push_refresh();
        run = 1'b1;
        @(negedge clk);
        chk(bus_wr && bus_addr == 2'd0, "R2 first op", {bus_wr, bus_addr}, 3'b100);
        while (ops_seen < 60) @(negedge clk);
        run = 1'b0;  // R10: mid-refresh drop, second refresh completes
        wait_drained(400);
        chk(ops_seen == 2 * 7 * NB, "R10 stop after refresh", ops_seen, 2 * 7 * NB);

        sw_model[3] = 8'hFF;
        sw_model[0] = 8'hFE;
        sw_model[6] = 8'h7F;
        push_refresh();
        run = 1'b1;
        @(negedge clk);
        run = 1'b0;  // R10: single-clock pulse gives one refresh
        wait_drained(300);
        chk(ops_seen == 3 * 7 * NB, "R10 single refresh", ops_seen, 3 * 7 * NB);
        chk(!bus_wr && !bus_rd, "R1 idle again", {bus_wr, bus_rd}, 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (100000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule